// File: doc/BRIEF.md
# Wake-Up Input Capture and Interrupt Controller

This block watches a set of wake-up pins and a group of other event sources. It drives one active-low interrupt line, which each source can mask on its own. Each pin passes through a two-stage synchronizer. An edge detector then picks disabled, rising, falling or both edges for that pin, as a 2-bit option sets. Detected events are held in sticky status registers. A read of a status register clears it.

Detection follows the operating mode, which an external mode controller supplies on `mode_i`. In Normal Request and Emergency, pin activity is ignored. In Normal and Stand-by, an event sets a flag and can raise the interrupt. In Sleep, an event sets a flag and sends a one-cycle wake request to the mode controller, and the local wake-up source does not raise the interrupt. A small read/write bus gives access to the registers. A read of either status register clears it.

Top module: `wake_irq_ctrl`

## Requirements
- R1: Register 0 (read-only) returns the synchronized level of every wake-up pin in bits [NUM_WAKE-1:0]. A pin change shows there after two rising clock edges.
- R2: Register 4 holds a 2-bit option per pin, in bits [2i+1:2i] for pin i. The codes are 00 disabled, 01 rising edge, 10 falling edge and 11 both edges.
- R3: In modes Normal (1), Stand-by (2) and Sleep (3), an enabled edge sets bit i of register 1. The flag is visible after the third rising edge that follows the pin change.
- R4: In modes Normal Request (0) and Emergency (4), wake-up pins set no flag and raise no wake request.
- R5: In Sleep, a detected edge drives `wake_req_o` high for one cycle, on the same edge that sets the flag. Local wake-up flags never pull `irq_no` low in Sleep.
- R6: Register 2 latches the event inputs as sticky flags, one rising edge after they are seen high. The bit order is: 0 battery overvoltage, 1 battery undervoltage, 2 regulator over-temperature, 3 regulator temperature pre-warning, 4 CAN bus fault, 5 SPI error, 6 bus wake-up.
- R7: Register 3 is the read/write mask. Bits 0 to 6 enable the matching event flags and bit 7 enables local wake-up. `irq_no` is low exactly while an enabled event flag is set, or while bit 7 is set with any wake flag set in Normal or Stand-by.
- R8: A read of register 1 or 2 returns the current flags and clears them at that edge. A flag set in the same cycle as the read survives the clear.
- R9: After reset, all registers read 0, `irq_no` is high and `wake_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode: 0 Normal Request, 1 Normal, 2 Stand-by, 3 Sleep, 4 Emergency |
| wk_i | input | NUM_WAKE | Asynchronous wake-up pins |
| ev_i | input | NUM_EV | Event source inputs, each sampled as a level |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe, clears the status register it addresses |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from the address |
| irq_no | output | 1 | Interrupt, active low |
| wake_req_o | output | 1 | One-cycle wake request to the mode controller |

## Verification
A pin change reaches the live register after two rising edges. The status flag and the wake request follow one edge later. An event input sets its flag one edge after it is driven. `irq_no` and `rdata_o` are combinational from register state. The bench drives inputs on falling edges and samples on falling edges. It waits exactly two or three falling edges after a pin change before it samples, so each check lands in the first cycle its result is due. The live register is sampled one edge early as well, to confirm that the value has not yet arrived.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;
  typedef enum logic [2:0] {
    M_NREQ    = 3'd0,
    M_NORMAL  = 3'd1,
    M_STANDBY = 3'd2,
    M_SLEEP   = 3'd3,
    M_EMERG   = 3'd4
  } mode_e;

  localparam logic [2:0] A_LIVE = 3'd0;
  localparam logic [2:0] A_WSTS = 3'd1;
  localparam logic [2:0] A_ESTS = 3'd2;
  localparam logic [2:0] A_MASK = 3'd3;
  localparam logic [2:0] A_OPT  = 3'd4;
endpackage

// File: rtl/wk_edge_det.sv
module wk_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] opt_i,
  input  logic       en_i,
  output logic       level_o,
  output logic       det_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level_o = sync_q[SYNC_STAGES-1];
  assign rise    = level_o & ~prev_q;
  assign fall    = ~level_o & prev_q;
  // opt bit0 = rising, bit1 = falling
  assign det_o   = en_i & ((opt_i[0] & rise) | (opt_i[1] & fall));

  AST_DET_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |=> (prev_q != $past(prev_q))); // R2
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (clr_i ? '0 : sts_q) | set_i;
  end

  assign sts_o = sts_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (($past(sts_o) & ~sts_o) == '0)); // R3
  AST_SET_SURVIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((sts_o & $past(set_i)) == $past(set_i))); // R8
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
  import wake_irq_pkg::*;
#(
  parameter int NUM_WAKE    = 4,
  parameter int NUM_EV      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          mode_i,
  input  logic [NUM_WAKE-1:0] wk_i,
  input  logic [NUM_EV-1:0]   ev_i,
  input  logic [2:0]          addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_no,
  output logic                wake_req_o
);
  localparam int OPT_W  = 2 * NUM_WAKE;
  localparam int MASK_W = NUM_EV + 1;

  logic [OPT_W-1:0]    opt_q;
  logic [MASK_W-1:0]   mask_q;
  logic [NUM_WAKE-1:0] wk_lvl, wk_det, wk_sts;
  logic [NUM_EV-1:0]   ev_sts;
  logic                det_en, wk_irq_en, clr_w, clr_e, wake_req_q, irq_act;

  assign det_en    = (mode_i == M_NORMAL) || (mode_i == M_STANDBY) || (mode_i == M_SLEEP);
  assign wk_irq_en = (mode_i == M_NORMAL) || (mode_i == M_STANDBY);

  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_pin
    wk_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (wk_i[i]),
      .opt_i  (opt_q[2*i +: 2]),
      .en_i   (det_en),
      .level_o(wk_lvl[i]),
      .det_o  (wk_det[i])
    );
  end

  assign clr_w = rd_i && (addr_i == A_WSTS);
  assign clr_e = rd_i && (addr_i == A_ESTS);

  irq_status #(.W(NUM_WAKE)) u_wsts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (wk_det),
    .clr_i (clr_w),
    .sts_o (wk_sts)
  );

  irq_status #(.W(NUM_EV)) u_ests (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ev_i),
    .clr_i (clr_e),
    .sts_o (ev_sts)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opt_q      <= '0;
      mask_q     <= '0;
      wake_req_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_OPT)  opt_q  <= wdata_i[OPT_W-1:0];
      if (wr_i && addr_i == A_MASK) mask_q <= wdata_i[MASK_W-1:0];
      wake_req_q <= (|wk_det) && (mode_i == M_SLEEP);
    end
  end

  assign wake_req_o = wake_req_q;
  assign irq_act = (|(ev_sts & mask_q[NUM_EV-1:0]))
                 | (mask_q[NUM_EV] & wk_irq_en & (|wk_sts));
  assign irq_no  = ~irq_act;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_LIVE: rdata_o[NUM_WAKE-1:0] = wk_lvl;
      A_WSTS: rdata_o[NUM_WAKE-1:0] = wk_sts;
      A_ESTS: rdata_o[NUM_EV-1:0]   = ev_sts;
      A_MASK: rdata_o[MASK_W-1:0]   = mask_q;
      A_OPT:  rdata_o[OPT_W-1:0]    = opt_q;
      default: ;
    endcase
  end

  AST_IDLE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == M_NREQ || mode_i == M_EMERG) && !clr_w) |=> $stable(wk_sts)); // R4
  AST_WREQ_IN_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> ($past(mode_i) == M_SLEEP)); // R5
  AST_WREQ_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> (|wk_sts)); // R5
  AST_SLEEP_WK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == M_SLEEP) && (ev_sts == '0)) |-> irq_no); // R5
  AST_ALL_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> irq_no); // R7
endmodule

// File: tb/wake_irq_ctrl_tb.sv
module wake_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic [3:0] wk_i = '0;
  logic [6:0] ev_i = '0;
  logic [2:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_no, wake_req_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wake_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .wk_i(wk_i), .ev_i(ev_i),
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_no(irq_no), .wake_req_o(wake_req_o)
  );

  // {mode[8:6], opt[5:4], from[3], to[2], exp_flag[1], exp_req[0]}
  localparam logic [8:0] VEC [10] = '{
    {3'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd2, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd2, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd3, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd3, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd4, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk(irq_no == 1'b1, "R9 irq_no", int'(irq_no), 1);
    chk(wake_req_o == 1'b0, "R9 wake_req", int'(wake_req_o), 0);
    for (int a = 0; a < 5; a++) begin
      addr_i = 3'(a);
      #1 chk(rdata_o == 8'h00, "R9 register", int'(rdata_o), 0);
    end
    @(negedge clk);

    wr_reg(3'd3, 8'hFF);
    rd_reg(3'd3, d);
    chk(d == 8'hFF, "R7 mask readback", int'(d), 'hFF);

    // R2 R3 R4 R5 vector walk on pin 0
    for (int v = 0; v < 10; v++) begin
      logic [2:0] m;
      logic [1:0] o;
      logic fr, to, ef, er, ei;
      {m, o, fr, to, ef, er} = VEC[v];
      wr_reg(3'd4, {4{o}});
      mode_i = m;
      wk_i[0] = fr;
      repeat (4) @(negedge clk);
      rd_reg(3'd1, d);
      wk_i[0] = to;
      repeat (3) @(negedge clk);
      ei = !(ef && (m == 3'd1 || m == 3'd2));
      chk(wake_req_o == er, $sformatf("R5 wake_req vec%0d", v), int'(wake_req_o), int'(er));
      chk(irq_no == ei, $sformatf("R7 irq vec%0d", v), int'(irq_no), int'(ei));
      rd_reg(3'd1, d);
      chk(d == {7'b0, ef}, $sformatf("R3/R4 flag vec%0d", v), int'(d), int'(ef));
      chk(wake_req_o == 1'b0, $sformatf("R5 pulse width vec%0d", v), int'(wake_req_o), 0);
      addr_i = 3'd0;
      #1 chk(rdata_o[0] == to, $sformatf("R1 live vec%0d", v), int'(rdata_o[0]), int'(to));
      @(negedge clk);
    end

    // R1 R2: pin 3 only rising, live delay
    wk_i = '0;
    mode_i = 3'd1;
    wr_reg(3'd4, 8'b01_00_00_00);
    repeat (4) @(negedge clk);
    rd_reg(3'd1, d);
    wr_reg(3'd3, 8'h00);
    addr_i = 3'd0;
    wk_i = 4'hF;
    @(negedge clk);
    chk(rdata_o == 8'h00, "R1 live after one edge", int'(rdata_o), 0);
    @(negedge clk);
    chk(rdata_o == 8'h0F, "R1 live after two edges", int'(rdata_o), 'h0F);
    @(negedge clk);
    chk(irq_no == 1'b1, "R7 local wake masked", int'(irq_no), 1);
    wr_reg(3'd3, 8'h80);
    chk(irq_no == 1'b0, "R7 local wake enabled", int'(irq_no), 0);
    rd_reg(3'd1, d);
    chk(d == 8'h08, "R2 option bit position", int'(d), 'h08);
    chk(irq_no == 1'b1, "R8 cleared wake flag", int'(irq_no), 1);

    // R6 R7 R8 event flags
    mode_i = 3'd0;
    wr_reg(3'd3, 8'h00);
    ev_i = 7'h04;
    @(negedge clk);
    ev_i = '0;
    chk(irq_no == 1'b1, "R7 event masked", int'(irq_no), 1);
    wr_reg(3'd3, 8'h04);
    chk(irq_no == 1'b0, "R7 event enabled", int'(irq_no), 0);
    ev_i = 7'h20;
    rd_reg(3'd2, d);
    ev_i = '0;
    chk(d == 8'h04, "R6 event flag", int'(d), 'h04);
    chk(irq_no == 1'b1, "R7 only masked flag left", int'(irq_no), 1);
    rd_reg(3'd2, d);
    chk(d == 8'h20, "R8 set during read kept", int'(d), 'h20);
    rd_reg(3'd2, d);
    chk(d == 8'h00, "R8 clear on read", int'(d), 0);

    done = 1'b1;
    finish_run();
  end
endmodule